// File: doc/BRIEF.md
# Real-Time Clock Seconds and Interrupt Core

This core keeps wall-clock time as a count of seconds and exposes it, together with an alarm comparator and a small interrupt controller, through a word-addressed register port. A separate tick generator drives it with a one-cycle pulse per second and a live sub-second tick count. On every pulse the seconds counter advances by one. If software has programmed a new time since the previous pulse, the counter loads that value instead. This keeps every second boundary on the tick grid.

Two event sources feed the interrupt logic: a seconds event raised on every pulse and an alarm event raised while the counter equals the alarm value. Each source has a sticky status bit that is cleared by writing one. Each source also has an enable bit that is set and cleared through two separate strobe registers. Every source drives its own registered interrupt pin. The calibration word is stored and forwarded to the tick generator with a one-cycle load strobe. The two power-control bits are only stored.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the current-time, status and enable registers read 0, the alarm register reads 0xFFFFFFFF, and both interrupt pins are low.
- R2: Each cycle with `sec_pulse` high and no pending set-time increments the current time (read at offset 0x10) by exactly one. Without a pulse the time does not change.
- R3: A write to offset 0x00 can be read back at once at offset 0x04, but it leaves the current time unchanged until the next pulse. At that pulse the current time becomes the written value, not that value plus one. Later pulses count on from it.
- R4: Status bit 0 (offset 0x20) sets on every second pulse. Writing 1 to it clears it, and writing 0 leaves it set. A pulse in the same cycle as a clearing write leaves it set.
- R5: Status bit 1 sets in every cycle in which the current time equals the alarm register (offset 0x18). A clearing write therefore holds only once the time has moved past the alarm value.
- R6: Writing 1 to bit n of offset 0x28 enables source n. Writing 1 to bit n of offset 0x2C disables it. Zero bits leave the enable unchanged. Offset 0x24 reads the enable bits.
- R7: `irq_sec` equals status bit 0 AND enable bit 0, and `irq_alarm` equals status bit 1 AND enable bit 1, each delayed by one register stage.
- R8: A write to offset 0x08 keeps the low 21 bits, which read back at offset 0x0C with the upper bits zero. In the cycle after the write, `cal_load` is high for one cycle and `cal_value` carries the stored value.
- R9: Offset 0x14 returns the `tick_cnt` input, zero-extended.
- R10: At offset 0x40 only bits 31 and 24 are writable and readable. All other bits read 0.
- R11: Reads of undefined offsets, including 0x1C and 0x30, return 0. Writes to them, and writes to the read-only offsets 0x04, 0x0C, 0x10, 0x14 and 0x24, change no state.
- R12: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds that value until the next read. The two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_pulse | input | 1 | One-cycle second boundary from the tick generator |
| tick_cnt | input | 16 | Sub-second tick count from the tick generator |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cal_load | output | 1 | One-cycle pulse after a calibration write |
| cal_value | output | 21 | Stored calibration word |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The counter is tested with plain pulses and with a set-time write placed between two pulses. The second case shows whether a programmed value is loaded on the boundary, applied at once, or applied off by one. The status logic is driven with clearing writes that come before, coincide with and follow an event. This separates set-over-clear priority from clear-wins behaviour, and shows whether the alarm bit re-arms while the match persists. Enable and disable writes with mixed bit patterns show that the two strobe registers act only on their one-bits. Writes to undefined and read-only offsets, each followed by reads of the state they might have changed, show that the decode is complete.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

   // word index (byte offset >> 2) of each register
   localparam logic [4:0] WI_SET_WR  = 5'd0;
   localparam logic [4:0] WI_SET_RD  = 5'd1;
   localparam logic [4:0] WI_CAL_WR  = 5'd2;
   localparam logic [4:0] WI_CAL_RD  = 5'd3;
   localparam logic [4:0] WI_CUR     = 5'd4;
   localparam logic [4:0] WI_TICK    = 5'd5;
   localparam logic [4:0] WI_ALARM   = 5'd6;
   localparam logic [4:0] WI_STS     = 5'd8;
   localparam logic [4:0] WI_MASK    = 5'd9;
   localparam logic [4:0] WI_IEN     = 5'd10;
   localparam logic [4:0] WI_IDIS    = 5'd11;
   localparam logic [4:0] WI_CTRL    = 5'd16;

   localparam int unsigned MIN_ADDR_W = 7;

   // interrupt sources, bit position in status/enable
   localparam int unsigned SRC_SEC   = 0;
   localparam int unsigned SRC_ALARM = 1;
   localparam int unsigned NUM_SRC   = 2;

   // stored-only control bits
   localparam int unsigned CTL_BATT_BIT = 31;
   localparam int unsigned CTL_OSC_BIT  = 24;

   typedef struct packed {
      logic set_time;
      logic calib;
      logic alarm;
      logic sts_clr;
      logic irq_on;
      logic irq_off;
      logic ctrl;
   } wr_strobe_t;

endpackage

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper #(
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_pulse,
   input  logic              load_wr,
   input  logic [TIME_W-1:0] load_val,
   output logic [TIME_W-1:0] cur_time,
   output logic [TIME_W-1:0] staged_time,
   output logic              staged_pend
);

   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   if (TIME_W < 8 || TIME_W > 64) begin : g_bad_w
      $error("rtc_time_keeper: TIME_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_time <= '0;
      end else if (load_wr) begin
         staged_time <= load_val;
      end
   end

   // a write in the same cycle as a pulse stays pending for the next pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_pend <= 1'b0;
      end else if (load_wr) begin
         staged_pend <= 1'b1;
      end else if (sec_pulse) begin
         staged_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_time <= '0;
      end else if (sec_pulse) begin
         if (staged_pend) begin
            cur_time <= staged_time;
         end else begin
            cur_time <= cur_time + ONE;
         end
      end
   end

   a_r2_hold_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_pulse |=> $stable(cur_time));

   a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !staged_pend) |=> cur_time == $past(cur_time) + ONE);

   a_r3_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && staged_pend) |=> cur_time == $past(staged_time));

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] event_set,
   input  logic             sts_clr_wr,
   input  logic             en_on_wr,
   input  logic             en_off_wr,
   input  logic [N_SRC-1:0] wbits,
   output logic [N_SRC-1:0] status,
   output logic [N_SRC-1:0] enable,
   output logic [N_SRC-1:0] irq
);

   if (N_SRC < 1 || N_SRC > 32) begin : g_bad_n
      $error("rtc_irq_unit: N_SRC out of range");
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      // event has priority over a same-cycle clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status[g] <= 1'b0;
         end else if (event_set[g]) begin
            status[g] <= 1'b1;
         end else if (sts_clr_wr && wbits[g]) begin
            status[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            enable[g] <= 1'b0;
         end else if (en_on_wr && wbits[g]) begin
            enable[g] <= 1'b1;
         end else if (en_off_wr && wbits[g]) begin
            enable[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq[g] <= 1'b0;
         end else begin
            irq[g] <= status[g] & enable[g];
         end
      end

      a_r4_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
         event_set[g] |=> status[g]);

      a_r6_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
         (en_on_wr && wbits[g]) |=> enable[g]);

      a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
         !(status[g] && enable[g]) |=> !irq[g]);
   end

endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
   import rtc_sec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned TIME_W   = 32,
   parameter int unsigned TICK_W   = 16,
   parameter int unsigned CAL_W    = 21,
   parameter int unsigned N_SRC    = 2,
   parameter logic [CAL_W-1:0] CAL_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] staged_time,
   input  logic [TICK_W-1:0] tick_cnt,
   input  logic [N_SRC-1:0]  status,
   input  logic [N_SRC-1:0]  enable,
   output wr_strobe_t        wr_stb,
   output logic [TIME_W-1:0] alarm_val,
   output logic              cal_load,
   output logic [CAL_W-1:0]  cal_value,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [DATA_W-1:0] CTL_KEEP =
      (DATA_W'(1) << CTL_BATT_BIT) | (DATA_W'(1) << CTL_OSC_BIT);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("rtc_reg_bank: ADDR_W too small for the register map");
   end
   if (TIME_W > DATA_W || TICK_W > DATA_W || CAL_W > DATA_W || N_SRC > DATA_W) begin : g_bad_fit
      $error("rtc_reg_bank: field wider than data bus");
   end
   if (DATA_W <= CTL_BATT_BIT) begin : g_bad_data
      $error("rtc_reg_bank: DATA_W must hold the control bits");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] rd_mux;

   assign idx = bus_addr[ADDR_W-1:2];

   function automatic logic hit(input logic [IDX_W-1:0] a, input logic [4:0] wi);
      return a == IDX_W'(wi);
   endfunction

   always_comb begin
      wr_stb          = '0;
      wr_stb.set_time = bus_wr && hit(idx, WI_SET_WR);
      wr_stb.calib    = bus_wr && hit(idx, WI_CAL_WR);
      wr_stb.alarm    = bus_wr && hit(idx, WI_ALARM);
      wr_stb.sts_clr  = bus_wr && hit(idx, WI_STS);
      wr_stb.irq_on   = bus_wr && hit(idx, WI_IEN);
      wr_stb.irq_off  = bus_wr && hit(idx, WI_IDIS);
      wr_stb.ctrl     = bus_wr && hit(idx, WI_CTRL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_val <= '1;
      end else if (wr_stb.alarm) begin
         alarm_val <= bus_wdata[TIME_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_value <= CAL_INIT;
         cal_load  <= 1'b0;
      end else begin
         cal_load <= wr_stb.calib;
         if (wr_stb.calib) begin
            cal_value <= bus_wdata[CAL_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_stb.ctrl) begin
         ctrl_q <= bus_wdata & CTL_KEEP;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit(idx, WI_SET_RD))     rd_mux = DATA_W'(staged_time);
      else if (hit(idx, WI_CAL_RD)) rd_mux = DATA_W'(cal_value);
      else if (hit(idx, WI_CUR))    rd_mux = DATA_W'(cur_time);
      else if (hit(idx, WI_TICK))   rd_mux = DATA_W'(tick_cnt);
      else if (hit(idx, WI_ALARM))  rd_mux = DATA_W'(alarm_val);
      else if (hit(idx, WI_STS))    rd_mux = DATA_W'(status);
      else if (hit(idx, WI_MASK))   rd_mux = DATA_W'(enable);
      else if (hit(idx, WI_CTRL))   rd_mux = ctrl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_mux;
      end
   end

   a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   a_r8_cal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cal_load |=> $stable(cal_value));

   a_r10_ctrl_only_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTL_KEEP) == '0);

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
   import rtc_sec_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TIME_W = 32,
   parameter int unsigned TICK_W = 16,
   parameter int unsigned CAL_W  = 21,
   parameter logic [CAL_W-1:0] CAL_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_pulse,
   input  logic [TICK_W-1:0] tick_cnt,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cal_load,
   output logic [CAL_W-1:0]  cal_value,
   output logic              irq_sec,
   output logic              irq_alarm
);

   wr_strobe_t         wr_stb;
   logic [TIME_W-1:0]  cur_time;
   logic [TIME_W-1:0]  staged_time;
   logic               staged_pend;
   logic [TIME_W-1:0]  alarm_val;
   logic               alarm_hit;
   logic [NUM_SRC-1:0] ev_set;
   logic [NUM_SRC-1:0] sts;
   logic [NUM_SRC-1:0] ena;
   logic [NUM_SRC-1:0] irq_vec;

   rtc_time_keeper #(.TIME_W(TIME_W)) u_time (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_pulse   (sec_pulse),
      .load_wr     (wr_stb.set_time),
      .load_val    (bus_wdata[TIME_W-1:0]),
      .cur_time    (cur_time),
      .staged_time (staged_time),
      .staged_pend (staged_pend)
   );

   assign alarm_hit          = (cur_time == alarm_val);
   assign ev_set[SRC_SEC]    = sec_pulse;
   assign ev_set[SRC_ALARM]  = alarm_hit;

   rtc_irq_unit #(.N_SRC(NUM_SRC)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .event_set  (ev_set),
      .sts_clr_wr (wr_stb.sts_clr),
      .en_on_wr   (wr_stb.irq_on),
      .en_off_wr  (wr_stb.irq_off),
      .wbits      (bus_wdata[NUM_SRC-1:0]),
      .status     (sts),
      .enable     (ena),
      .irq        (irq_vec)
   );

   rtc_reg_bank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TIME_W   (TIME_W),
      .TICK_W   (TICK_W),
      .CAL_W    (CAL_W),
      .N_SRC    (NUM_SRC),
      .CAL_INIT (CAL_INIT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .cur_time    (cur_time),
      .staged_time (staged_time),
      .tick_cnt    (tick_cnt),
      .status      (sts),
      .enable      (ena),
      .wr_stb      (wr_stb),
      .alarm_val   (alarm_val),
      .cal_load    (cal_load),
      .cal_value   (cal_value),
      .bus_rdata   (bus_rdata)
   );

   assign irq_sec   = irq_vec[SRC_SEC];
   assign irq_alarm = irq_vec[SRC_ALARM];

   a_r5_match_sets_alarm: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> sts[SRC_ALARM]);

   a_r3_staged_survives_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (staged_pend && !sec_pulse) |=> staged_pend);

endmodule

// File: tb/sim_rtc_seconds_core.sv
`timescale 1ns/1ps
module sim_rtc_seconds_core;

   localparam logic [6:0] A_SET_WR = 7'h00, A_SET_RD = 7'h04, A_CAL_WR = 7'h08,
                          A_CAL_RD = 7'h0C, A_CUR = 7'h10, A_TICK = 7'h14,
                          A_ALARM = 7'h18, A_STS = 7'h20, A_MASK = 7'h24,
                          A_IEN = 7'h28, A_IDIS = 7'h2C, A_CTRL = 7'h40,
                          A_HOLE1 = 7'h1C, A_HOLE2 = 7'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_pulse = 1'b0;
   logic [15:0] tick_cnt = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cal_load;
   logic [20:0] cal_value;
   logic        irq_sec;
   logic        irq_alarm;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_time = '0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   rtc_seconds_core u0 (
      .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .tick_cnt(tick_cnt),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cal_load(cal_load), .cal_value(cal_value),
      .irq_sec(irq_sec), .irq_alarm(irq_alarm)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse();
      @(negedge clk);
      sec_pulse = 1'b1;
      @(negedge clk);
      sec_pulse = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 irq_sec", {31'b0, irq_sec}, 32'h0);
      check("R1 irq_alarm", {31'b0, irq_alarm}, 32'h0);
      check("R1 rdata", bus_rdata, 32'h0);
      rd(A_CUR, rv);   check("R1 time", rv, 32'h0);
      rd(A_STS, rv);   check("R1 status", rv, 32'h0);
      rd(A_MASK, rv);  check("R1 enable", rv, 32'h0);
      rd(A_ALARM, rv); check("R1 alarm", rv, 32'hFFFF_FFFF);
   endtask

   task automatic t_count();
      for (int i = 0; i < 3; i++) begin pulse(); exp_time++; end
      idle(4);
      rd(A_CUR, rv); check("R2 count", rv, exp_time);
      rd(A_CUR | 7'h3, rv); check("R12 low bits ignored", rv, exp_time);
   endtask

   task automatic t_set_time();
      wr(A_SET_WR, 32'd100);
      rd(A_CUR, rv);    check("R3 not yet applied", rv, exp_time);
      rd(A_SET_RD, rv); check("R3 staged readback", rv, 32'd100);
      pulse(); exp_time = 32'd100;
      rd(A_CUR, rv);    check("R3 loaded", rv, exp_time);
      pulse(); exp_time++;
      rd(A_CUR, rv);    check("R3 counts on", rv, exp_time);
   endtask

   task automatic t_sec_status();
      wr(A_STS, 32'h1);
      rd(A_STS, rv); check("R4 cleared", rv & 32'h1, 32'h0);
      pulse(); exp_time++;
      rd(A_STS, rv); check("R4 set by pulse", rv & 32'h1, 32'h1);
      wr(A_STS, 32'h0);
      rd(A_STS, rv); check("R4 zero write keeps", rv & 32'h1, 32'h1);
      wr(A_STS, 32'h1);
      @(negedge clk);
      sec_pulse = 1'b1; bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h1;
      @(negedge clk);
      sec_pulse = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      exp_time++;
      rd(A_STS, rv); check("R4 set beats clear", rv & 32'h1, 32'h1);
   endtask

   task automatic t_alarm();
      wr(A_ALARM, exp_time + 32'd2);
      rd(A_STS, rv); check("R5 no match yet", rv & 32'h2, 32'h0);
      pulse(); exp_time++;
      pulse(); exp_time++;
      rd(A_STS, rv); check("R5 match sets", rv & 32'h2, 32'h2);
      wr(A_STS, 32'h2);
      rd(A_STS, rv); check("R5 re-asserts while matching", rv & 32'h2, 32'h2);
      pulse(); exp_time++;
      wr(A_STS, 32'h2);
      rd(A_STS, rv); check("R5 clear holds after match", rv & 32'h2, 32'h0);
   endtask

   task automatic t_irq();
      wr(A_STS, 32'h3);
      wr(A_IEN, 32'h1);
      rd(A_MASK, rv); check("R6 enable sec", rv, 32'h1);
      idle(2);
      check("R7 no irq without status", {31'b0, irq_sec}, 32'h0);
      pulse(); exp_time++;
      idle(2);
      check("R7 irq_sec high", {31'b0, irq_sec}, 32'h1);
      check("R7 irq_alarm low", {31'b0, irq_alarm}, 32'h0);
      wr(A_STS, 32'h1);
      idle(2);
      check("R7 irq_sec drops", {31'b0, irq_sec}, 32'h0);
      wr(A_ALARM, exp_time);
      wr(A_IEN, 32'h2);
      rd(A_MASK, rv); check("R6 both enabled", rv, 32'h3);
      idle(2);
      check("R7 irq_alarm high", {31'b0, irq_alarm}, 32'h1);
      wr(A_IDIS, 32'h2);
      rd(A_MASK, rv); check("R6 disable alarm only", rv, 32'h1);
      idle(2);
      check("R7 irq_alarm off", {31'b0, irq_alarm}, 32'h0);
      wr(A_IDIS, 32'h0);
      rd(A_MASK, rv); check("R6 zero disable keeps", rv, 32'h1);
   endtask

   task automatic t_cal_tick_ctrl();
      wr(A_CAL_WR, 32'hFFFF_FFFF);
      check("R8 cal_load pulse", {31'b0, cal_load}, 32'h1);
      check("R8 cal_value", {11'b0, cal_value}, 32'h001F_FFFF);
      @(negedge clk);
      check("R8 cal_load one cycle", {31'b0, cal_load}, 32'h0);
      rd(A_CAL_RD, rv); check("R8 cal readback", rv, 32'h001F_FFFF);
      tick_cnt = 16'hABCD;
      rd(A_TICK, rv); check("R9 tick", rv, 32'h0000_ABCD);
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, rv); check("R10 ctrl bits", rv, 32'h8100_0000);
      wr(A_CTRL, 32'h0100_0000);
      rd(A_CTRL, rv); check("R10 ctrl clear", rv, 32'h0100_0000);
   endtask

   task automatic t_undefined();
      wr(A_HOLE1, 32'hFFFF_FFFF);
      wr(A_SET_RD, 32'h1234_5678);
      wr(A_CUR, 32'h0000_0055);
      wr(A_MASK, 32'h0000_0003);
      wr(A_CAL_RD, 32'h0000_0001);
      rd(A_HOLE1, rv);  check("R11 hole 0x1C", rv, 32'h0);
      rd(A_HOLE2, rv);  check("R11 hole 0x30", rv, 32'h0);
      rd(A_SET_RD, rv); check("R11 staged unchanged", rv, 32'd100);
      rd(A_CUR, rv);    check("R11 time unchanged", rv, exp_time);
      rd(A_MASK, rv);   check("R11 enable unchanged", rv, 32'h1);
      rd(A_CAL_RD, rv); check("R11 cal unchanged", rv, 32'h001F_FFFF);
      rd(A_CUR, rv);
      pulse(); exp_time++;
      idle(2);
      check("R12 rdata holds", bus_rdata, exp_time - 32'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_count();
      t_set_time();
      t_sec_status();
      t_alarm();
      t_irq();
      t_cal_tick_ctrl();
      t_undefined();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule